// File: doc/BRIEF.md
# Address-Range Memory Protection Checker

This block decides, for every bus access, whether the access is permitted. It holds a small table of protection regions. Each region is described by a first and a last 32-byte granule, an enable bit and a two-bit access attribute. Regions may start and end on any granule. There is no size-alignment rule, and the size need not be a power of two. Every access presents an address and an access kind: instruction fetch, data read or data write. The block answers combinationally with an allow bit. It also reports which region, if any, decided the answer.

Software loads one whole region per clock through a single write port. Two global control bits select the overall behaviour. One switches protection on or off. The other chooses what happens to an address that no enabled region covers. One attribute value marks a region as execute-only. Code placed there can be fetched, but it can never be read back or overwritten as data.

When a valid access is refused, the block records the offending address and access kind. It also raises a sticky fault flag that stays set until software clears it.

Top module: `mpu_range_checker`

## Requirements
- R1: `cfg_start` and `cfg_end` are granule numbers, meaning address bits [ADDR_W-1:5]. An enabled region matches an address whose granule number g satisfies start <= g <= end. Address bits [4:0] never affect matching.
- R2: Any start/end pair with start <= end is a legal region. This includes unaligned starts, single-granule regions and sizes that are not powers of two.
- R3: A region never matches when its enable bit is 0. It also never matches when its end granule is below its start granule.
- R4: When several enabled regions match, the one with the highest index decides. `req_hit` is 1 when any enabled region matches. `req_region` then gives that index, and it is 0 when nothing matches.
- R5: The access kind `req_acc` is encoded as 00 fetch, 01 read, 10 write, and 11 is treated as a write. The attribute `cfg_attr` is encoded as follows:
  - 00 denies every access kind.
  - 01 allows fetch and read.
  - 10 allows all access kinds.
  - 11 (execute-only) allows fetch only.
- R6: A region write with `cfg_we` high is applied at the rising clock edge. Accesses before that edge see the old region, and accesses after it see the new one.
- R7: After reset, protection is off and all regions are disabled. While the stored global enable is 0, every access is allowed.
- R8: While protection is on, an access that matches no enabled region is allowed exactly when the stored background bit is 1. Both bits are loaded by `ctl_we` at a clock edge.
- R9: `req_allow` is combinational and does not depend on `req_valid`. A fault is `req_valid` high with `req_allow` low. A fault with the flag clear sets `flt_sticky` at the next edge and stores `flt_addr` and `flt_acc`. Requests with `req_valid` low are never logged.
- R10: `flt_sticky` stays set until `flt_clr` is high at an edge. While the flag is set, later faults do not overwrite the stored address or kind. A fault in the same cycle as `flt_clr` is captured and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Region write strobe |
| cfg_idx | input | IDX_W (3) | Index of the region being written |
| cfg_start | input | ADDR_W-5 (27) | First granule of the region |
| cfg_end | input | ADDR_W-5 (27) | Last granule of the region, inclusive |
| cfg_enable | input | 1 | Region enable |
| cfg_attr | input | 2 | Region access attribute |
| ctl_we | input | 1 | Global control write strobe |
| ctl_enable | input | 1 | Global protection enable |
| ctl_bg_allow | input | 1 | Background policy for unmatched accesses |
| req_valid | input | 1 | Access is real and may be logged |
| req_addr | input | ADDR_W (32) | Access address |
| req_acc | input | 2 | Access kind |
| flt_clr | input | 1 | Clears the sticky fault flag |
| req_allow | output | 1 | Access permitted |
| req_hit | output | 1 | Some enabled region matches |
| req_region | output | IDX_W (3) | Deciding region index |
| flt_sticky | output | 1 | Sticky fault flag |
| flt_addr | output | ADDR_W (32) | Address of the logged fault |
| flt_acc | output | 2 | Access kind of the logged fault |

## Verification
The hardest situation to reach is a deep overlap: one address covered by three or four enabled regions at once, each with a different attribute. In that case only the highest index may decide. The address also sits next to regions that are disabled or whose bounds are inverted, and those must stay silent. The bench programs a fixed map with nested regions, stacking an execute-only granule inside a read-only span inside a read-write span, plus a deny region. It then sweeps every granule of the covered window at both granule edges, with all four access kinds. Each result is compared with an arithmetic model built from the attribute table. A second hard case is a fault that coincides with a flag clear. The bench drives both in one cycle after a fault is already held.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
   localparam logic [1:0] ACC_FETCH = 2'b00;
   localparam logic [1:0] ACC_READ  = 2'b01;
   localparam logic [1:0] ACC_WRITE = 2'b10;

   localparam logic [1:0] ATTR_NONE = 2'b00;
   localparam logic [1:0] ATTR_RO   = 2'b01;
   localparam logic [1:0] ATTR_RW   = 2'b10;
   localparam logic [1:0] ATTR_XO   = 2'b11;

   function automatic logic attr_permits(input logic [1:0] attr, input logic [1:0] acc);
      logic ok;
      case (attr)
         ATTR_RO: ok = (acc == ACC_FETCH) || (acc == ACC_READ);
         ATTR_RW: ok = 1'b1;
         ATTR_XO: ok = (acc == ACC_FETCH);
         default: ok = 1'b0;
      endcase
      return ok;
   endfunction
endpackage

// File: rtl/mpu_region_slot.sv
module mpu_region_slot #(
   parameter int GW = 27
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [GW-1:0] wr_start,
   input  logic [GW-1:0] wr_end,
   input  logic          wr_enable,
   input  logic [1:0]    wr_attr,
   input  logic [GW-1:0] req_gran,
   output logic          hit,
   output logic [1:0]    attr
);
   logic [GW-1:0] start_q;
   logic [GW-1:0] end_q;
   logic          en_q;
   logic [1:0]    attr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         end_q   <= '0;
         en_q    <= 1'b0;
         attr_q  <= 2'b00;
      end else if (wr_en) begin
         start_q <= wr_start;
         end_q   <= wr_end;
         en_q    <= wr_enable;
         attr_q  <= wr_attr;
      end
   end

   // an inverted pair (start > end) can satisfy neither bound at once
   assign hit  = en_q && (req_gran >= start_q) && (req_gran <= end_q);
   assign attr = attr_q;
endmodule

// File: rtl/mpu_prio_sel.sv
module mpu_prio_sel #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]      hit_vec,
   input  logic [N-1:0][1:0] attr_vec,
   output logic              any_hit,
   output logic [IDX_W-1:0]  win_idx,
   output logic [1:0]        win_attr
);
   always_comb begin
      any_hit  = 1'b0;
      win_idx  = '0;
      win_attr = 2'b00;
      // ascending scan: a later (higher) hit overwrites an earlier one
      for (int i = 0; i < N; i++) begin
         if (hit_vec[i]) begin
            any_hit  = 1'b1;
            win_idx  = IDX_W'(i);
            win_attr = attr_vec[i];
         end
      end
   end
endmodule

// File: rtl/mpu_fault_log.sv
module mpu_fault_log #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fault_ev,
   input  logic              clr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        acc,
   output logic              sticky,
   output logic [ADDR_W-1:0] faddr,
   output logic [1:0]        facc
);
   logic capture;
   assign capture = fault_ev && (!sticky || clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky <= 1'b0;
         faddr  <= '0;
         facc   <= 2'b00;
      end else begin
         sticky <= fault_ev || (sticky && !clr);
         if (capture) begin
            faddr <= addr;
            facc  <= acc;
         end
      end
   end
endmodule

// File: rtl/mpu_range_checker.sv
module mpu_range_checker #(
   parameter int ADDR_W      = 32,
   parameter int NUM_REGIONS = 8,
   parameter int GRAN_BITS   = 5,
   localparam int GW         = ADDR_W - GRAN_BITS,
   localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [GW-1:0]     cfg_start,
   input  logic [GW-1:0]     cfg_end,
   input  logic              cfg_enable,
   input  logic [1:0]        cfg_attr,
   input  logic              ctl_we,
   input  logic              ctl_enable,
   input  logic              ctl_bg_allow,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_acc,
   input  logic              flt_clr,
   output logic              req_allow,
   output logic              req_hit,
   output logic [IDX_W-1:0]  req_region,
   output logic              flt_sticky,
   output logic [ADDR_W-1:0] flt_addr,
   output logic [1:0]        flt_acc
);
   if (GRAN_BITS < 1 || GRAN_BITS >= ADDR_W) begin : g_bad_gran
      $error("GRAN_BITS must lie between 1 and ADDR_W-1");
   end
   if (NUM_REGIONS < 1 || NUM_REGIONS > 64) begin : g_bad_count
      $error("NUM_REGIONS must lie between 1 and 64");
   end

   logic glob_en_q;
   logic bg_allow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_en_q  <= 1'b0;
         bg_allow_q <= 1'b0;
      end else if (ctl_we) begin
         glob_en_q  <= ctl_enable;
         bg_allow_q <= ctl_bg_allow;
      end
   end

   logic [GW-1:0]               req_gran;
   logic [NUM_REGIONS-1:0]      hit_vec;
   logic [NUM_REGIONS-1:0][1:0] attr_vec;
   logic                        any_hit;
   logic [IDX_W-1:0]            win_idx;
   logic [1:0]                  win_attr;

   assign req_gran = req_addr[ADDR_W-1:GRAN_BITS];

   for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_slot
      mpu_region_slot #(.GW(GW)) i_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (cfg_we && (cfg_idx == IDX_W'(i))),
         .wr_start  (cfg_start),
         .wr_end    (cfg_end),
         .wr_enable (cfg_enable),
         .wr_attr   (cfg_attr),
         .req_gran  (req_gran),
         .hit       (hit_vec[i]),
         .attr      (attr_vec[i])
      );
   end

   mpu_prio_sel #(.N(NUM_REGIONS), .IDX_W(IDX_W)) i_prio (
      .hit_vec  (hit_vec),
      .attr_vec (attr_vec),
      .any_hit  (any_hit),
      .win_idx  (win_idx),
      .win_attr (win_attr)
   );

   always_comb begin
      if (!glob_en_q)    req_allow = 1'b1;
      else if (any_hit)  req_allow = mpu_pkg::attr_permits(win_attr, req_acc);
      else               req_allow = bg_allow_q;
   end

   assign req_hit    = any_hit;
   assign req_region = win_idx;

   mpu_fault_log #(.ADDR_W(ADDR_W)) i_log (
      .clk      (clk),
      .rst_n    (rst_n),
      .fault_ev (req_valid && !req_allow),
      .clr      (flt_clr),
      .addr     (req_addr),
      .acc      (req_acc),
      .sticky   (flt_sticky),
      .faddr    (flt_addr),
      .facc     (flt_acc)
   );
endmodule

// File: rtl/mpu_range_checker_sva.sv
module mpu_range_checker_sva #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_acc,
   input logic              req_allow,
   input logic              flt_clr,
   input logic              flt_sticky,
   input logic [ADDR_W-1:0] flt_addr,
   input logic [1:0]        flt_acc,
   input logic              glob_en_q,
   input logic              bg_allow_q,
   input logic              any_hit,
   input logic [1:0]        win_attr
);
   assert_off_allows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en_q |-> req_allow);

   assert_xo_blocks_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (glob_en_q && any_hit && win_attr == 2'b11 && req_acc != 2'b00) |-> !req_allow);

   assert_nohit_background_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (glob_en_q && !any_hit) |-> (req_allow == bg_allow_q));

   assert_fault_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_allow) |=> flt_sticky);

   assert_fault_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_allow && (!flt_sticky || flt_clr))
      |=> (flt_addr == $past(req_addr) && flt_acc == $past(req_acc)));

   assert_flag_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_sticky && !flt_clr) |=> flt_sticky);

   assert_log_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_sticky && !flt_clr) |=> ($stable(flt_addr) && $stable(flt_acc)));

   assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_clr && !(req_valid && !req_allow)) |=> !flt_sticky);
endmodule

bind mpu_range_checker mpu_range_checker_sva #(.ADDR_W(ADDR_W)) i_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_addr   (req_addr),
   .req_acc    (req_acc),
   .req_allow  (req_allow),
   .flt_clr    (flt_clr),
   .flt_sticky (flt_sticky),
   .flt_addr   (flt_addr),
   .flt_acc    (flt_acc),
   .glob_en_q  (glob_en_q),
   .bg_allow_q (bg_allow_q),
   .any_hit    (any_hit),
   .win_attr   (win_attr)
);

// File: tb/test_mpu_range_checker.sv
module test_mpu_range_checker;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int NR = 8;
   localparam int GW = AW - 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_idx = '0;
   logic [GW-1:0] cfg_start = '0;
   logic [GW-1:0] cfg_end = '0;
   logic          cfg_enable = 1'b0;
   logic [1:0]    cfg_attr = '0;
   logic          ctl_we = 1'b0;
   logic          ctl_enable = 1'b0;
   logic          ctl_bg_allow = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_acc = '0;
   logic          flt_clr = 1'b0;
   logic          req_allow;
   logic          req_hit;
   logic [2:0]    req_region;
   logic          flt_sticky;
   logic [AW-1:0] flt_addr;
   logic [1:0]    flt_acc;

   int checks = 0;
   int errors = 0;

   // bench-side model of the programmed state
   logic          m_en  [NR];
   int            m_s   [NR];
   int            m_e   [NR];
   logic [1:0]    m_at  [NR];
   logic          m_gen = 1'b0;
   logic          m_bg  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mpu_range_checker i_mpu_range_checker (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_enable(cfg_enable),
      .cfg_attr(cfg_attr), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
      .ctl_bg_allow(ctl_bg_allow), .req_valid(req_valid), .req_addr(req_addr),
      .req_acc(req_acc), .flt_clr(flt_clr), .req_allow(req_allow),
      .req_hit(req_hit), .req_region(req_region), .flt_sticky(flt_sticky),
      .flt_addr(flt_addr), .flt_acc(flt_acc)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic permits(input logic [1:0] at, input logic [1:0] acc);
      if (at == 2'b10) return 1'b1;
      if (at == 2'b01) return acc == 2'b00 || acc == 2'b01;
      if (at == 2'b11) return acc == 2'b00;
      return 1'b0;
   endfunction

   // highest matching index found by scanning downward
   function automatic int find_win(input int g);
      for (int r = NR - 1; r >= 0; r--)
         if (m_en[r] && g >= m_s[r] && g <= m_e[r]) return r;
      return -1;
   endfunction

   task automatic write_region(input int idx, input int s, input int e,
                               input logic en, input logic [1:0] at);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_start = GW'(s); cfg_end = GW'(e);
      cfg_enable = en; cfg_attr = at;
      @(negedge clk);
      cfg_we = 1'b0;
      m_en[idx] = en; m_s[idx] = s; m_e[idx] = e; m_at[idx] = at;
   endtask

   task automatic write_ctl(input logic en, input logic bg);
      @(negedge clk);
      ctl_we = 1'b1; ctl_enable = en; ctl_bg_allow = bg;
      @(negedge clk);
      ctl_we = 1'b0;
      m_gen = en; m_bg = bg;
   endtask

   // granules 0..47, both granule edges, all four access kinds
   task automatic sweep(input string tag);
      req_valid = 1'b0;
      for (int g = 0; g < 48; g++) begin
         for (int o = 0; o < 2; o++) begin
            for (int a = 0; a < 4; a++) begin
               int w;
               logic ex;
               @(negedge clk);
               req_addr = AW'(g * 32 + o * 31);
               req_acc  = 2'(a);
               #1;
               w = find_win(g);
               if (!m_gen)      ex = 1'b1;
               else if (w >= 0) ex = permits(m_at[w], 2'(a));
               else             ex = m_bg;
               check({tag, " allow"}, {31'b0, req_allow}, {31'b0, ex});
               check("R4 hit", {31'b0, req_hit}, {31'b0, (w >= 0)});
               check("R4 region", {29'b0, req_region}, (w >= 0) ? 32'(w) : 32'd0);
            end
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int r = 0; r < NR; r++) begin
         m_en[r] = 1'b0; m_s[r] = 0; m_e[r] = 0; m_at[r] = 2'b00;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7 reset state: protection off, everything allowed, no flag
      req_addr = 32'h0000_0440; req_acc = 2'b10; #1;
      check("R7 reset allow", {31'b0, req_allow}, 32'd1);
      check("R7 reset sticky", {31'b0, flt_sticky}, 32'd0);
      check("R7 reset flt_addr", flt_addr, 32'd0);

      // R8 background fault, then background allow, with no regions
      write_ctl(1'b1, 1'b0);
      sweep("R8 bg-fault");
      write_ctl(1'b1, 1'b1);
      sweep("R8 bg-allow");

      // R1 R2 R3 R4 R5 nested and odd-shaped map
      write_ctl(1'b1, 1'b0);
      write_region(0, 3, 13, 1'b1, 2'b10);   // read-write, 11 granules, unaligned
      write_region(1, 5, 8, 1'b1, 2'b01);    // read-only inside region 0
      write_region(2, 7, 7, 1'b1, 2'b11);    // single execute-only granule
      write_region(3, 10, 20, 1'b1, 2'b00);  // deny, overlaps region 0 top
      write_region(4, 30, 25, 1'b1, 2'b10);  // inverted bounds: R3
      write_region(5, 35, 40, 1'b0, 2'b10);  // disabled: R3
      write_region(6, 22, 22, 1'b1, 2'b11);  // execute-only
      write_region(7, 40, 44, 1'b1, 2'b01);
      sweep("R5 map");
      write_ctl(1'b1, 1'b1);
      sweep("R8 map-bg-allow");
      write_ctl(1'b0, 1'b0);
      sweep("R7 off");
      write_ctl(1'b1, 1'b0);

      // R6 write timing: region 5 becomes enabled read-write over granule 36
      @(negedge clk);
      req_valid = 1'b0; req_addr = 36 * 32 + 4; req_acc = 2'b10;
      cfg_we = 1'b1; cfg_idx = 3'd5; cfg_start = GW'(35); cfg_end = GW'(40);
      cfg_enable = 1'b1; cfg_attr = 2'b10;
      #1;
      check("R6 before edge", {31'b0, req_allow}, 32'd0);
      @(negedge clk);
      cfg_we = 1'b0;
      m_en[5] = 1'b1;
      #1;
      check("R6 after edge", {31'b0, req_allow}, 32'd1);

      // R9 fault logging: a data read of execute-only granule 22
      @(negedge clk);
      req_valid = 1'b0; req_addr = 22 * 32 + 8; req_acc = 2'b01;
      @(negedge clk);
      check("R9 invalid not logged", {31'b0, flt_sticky}, 32'd0);
      req_valid = 1'b1; #1;
      check("R9 comb deny", {31'b0, req_allow}, 32'd0);
      check("R9 flag before edge", {31'b0, flt_sticky}, 32'd0);
      @(negedge clk);
      check("R9 flag set", {31'b0, flt_sticky}, 32'd1);
      check("R9 addr", flt_addr, 22 * 32 + 8);
      check("R9 acc", {30'b0, flt_acc}, 32'd1);
      // R10 second fault does not overwrite
      req_addr = 10 * 32; req_acc = 2'b00;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 addr kept", flt_addr, 22 * 32 + 8);
      check("R10 acc kept", {30'b0, flt_acc}, 32'd1);
      repeat (2) @(negedge clk);
      check("R10 flag holds", {31'b0, flt_sticky}, 32'd1);
      // R10 clear together with a new fault: captured, flag stays set
      flt_clr = 1'b1; req_valid = 1'b1; req_addr = 3 * 32 + 2; req_acc = 2'b11;
      #1;
      check("R5 type 11 as write", {31'b0, req_allow}, 32'd1);
      req_addr = 12 * 32 + 2;
      @(negedge clk);
      check("R10 clr+fault flag", {31'b0, flt_sticky}, 32'd1);
      check("R10 clr+fault addr", flt_addr, 12 * 32 + 2);
      check("R10 clr+fault acc", {30'b0, flt_acc}, 32'd3);
      // R10 plain clear
      req_valid = 1'b0;
      @(negedge clk);
      flt_clr = 1'b0;
      check("R10 cleared", {31'b0, flt_sticky}, 32'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule